// File: doc/BRIEF.md
# One-Time-Programmable Byte Array Controller

This block gives a host register-level access to a one-time-programmable byte array. The host writes a byte address into two registers, picks a function (read or program), and starts the operation by writing the go bit. It then polls a busy flag until the operation finishes and checks a fail flag. After a successful read, the addressed byte appears in a read-data register. A program operation can only set bits, so the stored byte becomes the old value ORed with the program data.

A power-down control starts out set at reset and must be cleared before any operation can succeed. A separate byte-program enable must also be set before a program is accepted. The array itself is a behavioural model inside the block. It is all zeros at reset, and its depth is a parameter. Every operation keeps busy high for `BUSY_CYCLES` clock cycles. The register bus is plain and synchronous: writes take effect at the clock edge, and reads are combinational from the register address.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: After reset, the following hold. Power-down (offset 0x00, bit 0) reads 1. Status (0x30), fail (0x2C) and read-data (0x18) read 0. Every array byte is 0.
- R2: Byte address bits 12:8 live in bits 4:0 of offset 0x04. Address bits 7:0 live in bits 7:0 of offset 0x08. Program data uses bits 7:0 of 0x10. Byte-program enable is bit 0 of 0x14. The function field is bits 1:0 of 0x20. All of these read back what was written.
- R3: Writing 1 to bit 0 of offset 0x28 while idle launches an operation. Offset 0x28 always reads 0. Status bit 0 is 1 for exactly `BUSY_CYCLES` cycles, starting with the cycle after the go write.
- R4: A go write made while busy is ignored. The running operation keeps its end time and its captured command.
- R5: A read (function = 1) that passes puts the addressed byte into read-data bits 7:0 as busy falls, and clears fail.
- R6: A program (function = 2) that passes, launched with byte-program enable set, stores the old byte ORed with the program data.
- R7: An operation launched while power-down is 1 fails. Fail bit 0 reads 1 after busy falls.
- R8: A program launched while byte-program enable is 0 fails.
- R9: A function value of 0 or 3 fails.
- R10: A failed operation leaves the array and read-data unchanged.
- R11: Address bits at or above `ARRAY_AW` are ignored, so addresses that differ only in those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register byte offset |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |

## Verification
The assertions check the following on every cycle:
- an idle go always raises busy;
- the captured command, the fail flag and read-data hold steady while an operation is in flight;
- each array write only ever sets bits.

The busy length, the OR-accumulating program results, each of the three failure causes, and address aliasing can only be shown by the bench. It does this with sweeps over the whole array in a reduced configuration, comparing against a byte model kept in the bench.

// File: rtl/otp_cmd_pkg.sv
package otp_cmd_pkg;
  localparam int BUS_AW    = 6;
  localparam int BYTE_AW   = 13;
  localparam logic [BUS_AW-1:0] OFS_PWRDN  = 6'h00;
  localparam logic [BUS_AW-1:0] OFS_ADDR_H = 6'h04;
  localparam logic [BUS_AW-1:0] OFS_ADDR_L = 6'h08;
  localparam logic [BUS_AW-1:0] OFS_PDATA  = 6'h10;
  localparam logic [BUS_AW-1:0] OFS_PMODE  = 6'h14;
  localparam logic [BUS_AW-1:0] OFS_RDATA  = 6'h18;
  localparam logic [BUS_AW-1:0] OFS_FUNC   = 6'h20;
  localparam logic [BUS_AW-1:0] OFS_GO     = 6'h28;
  localparam logic [BUS_AW-1:0] OFS_FAIL   = 6'h2C;
  localparam logic [BUS_AW-1:0] OFS_STATUS = 6'h30;

  localparam logic [1:0] FN_READ = 2'b01;
  localparam logic [1:0] FN_PROG = 2'b10;

  typedef struct packed {
    logic [BYTE_AW-1:0] addr;
    logic [7:0]         data;
    logic               is_read;
    logic               is_prog;
    logic               bad;
  } otp_cmd_t;
endpackage

// File: rtl/otp_array_model.sv
module otp_array_model #(
  parameter int ARRAY_AW = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ARRAY_AW-1:0] addr,
  input  logic                we,
  input  logic [7:0]          wbyte,
  output logic [7:0]          rbyte
);
  localparam int DEPTH = 1 << ARRAY_AW;

  logic [7:0] mem_q [DEPTH];

  assign rbyte = mem_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else if (we) begin
      mem_q[addr] <= wbyte;
    end
  end

  AST_ONLY_SETS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((mem_q[$past(addr)] & $past(rbyte)) == $past(rbyte))); // R6
endmodule

// File: rtl/otp_op_seq.sv
module otp_op_seq
  import otp_cmd_pkg::*;
#(
  parameter int ARRAY_AW    = 10,
  parameter int BUSY_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                pwrdn,
  input  logic                pmode,
  input  logic [1:0]          func,
  input  logic [BYTE_AW-1:0]  addr,
  input  logic [7:0]          pdata,
  output logic                busy,
  output logic                fail,
  output logic [7:0]          rd_byte,
  output logic [ARRAY_AW-1:0] arr_addr,
  output logic                arr_we,
  output logic [7:0]          arr_wbyte,
  input  logic [7:0]          arr_rbyte
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

  otp_cmd_t         cmd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;
  logic             launch_bad;

  assign last       = busy && (cnt_q == '0);
  assign launch_bad = pwrdn || (func != FN_READ && func != FN_PROG) ||
                      (func == FN_PROG && !pmode);

  assign arr_addr  = cmd_q.addr[ARRAY_AW-1:0];
  assign arr_we    = last && !cmd_q.bad && cmd_q.is_prog;
  assign arr_wbyte = arr_rbyte | cmd_q.data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt_q   <= '0;
      cmd_q   <= '0;
      fail    <= 1'b0;
      rd_byte <= 8'h00;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        fail <= cmd_q.bad;
        if (!cmd_q.bad && cmd_q.is_read) rd_byte <= arr_rbyte;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (go) begin
      busy          <= 1'b1;
      cnt_q         <= CNT_LOAD;
      cmd_q.addr    <= addr;
      cmd_q.data    <= pdata;
      cmd_q.is_read <= (func == FN_READ);
      cmd_q.is_prog <= (func == FN_PROG);
      cmd_q.bad     <= launch_bad;
    end
  end

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go) |=> busy); // R3
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> $stable(cmd_q)); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> ($stable(fail) && $stable(rd_byte))); // R5
  AST_NO_WRITE_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |=> (!fail && !busy)); // R10
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_cmd_pkg::*;
#(
  parameter int ARRAY_AW    = 10,
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  logic               pwrdn_q, pmode_q;
  logic [4:0]         addr_hi_q;
  logic [7:0]         addr_lo_q;
  logic [7:0]         pdata_q;
  logic [1:0]         func_q;
  logic               go;
  logic               busy, fail;
  logic [7:0]         rd_byte;
  logic [ARRAY_AW-1:0] arr_addr;
  logic               arr_we;
  logic [7:0]         arr_wbyte, arr_rbyte;
  logic               unused_wdata;

  assign unused_wdata = ^bus_wdata[31:8];
  assign go = bus_we && (bus_addr == OFS_GO) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwrdn_q   <= 1'b1;
      pmode_q   <= 1'b0;
      addr_hi_q <= '0;
      addr_lo_q <= '0;
      pdata_q   <= '0;
      func_q    <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_PWRDN:  pwrdn_q   <= bus_wdata[0];
        OFS_ADDR_H: addr_hi_q <= bus_wdata[4:0];
        OFS_ADDR_L: addr_lo_q <= bus_wdata[7:0];
        OFS_PDATA:  pdata_q   <= bus_wdata[7:0];
        OFS_PMODE:  pmode_q   <= bus_wdata[0];
        OFS_FUNC:   func_q    <= bus_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_PWRDN:  bus_rdata[0]   = pwrdn_q;
      OFS_ADDR_H: bus_rdata[4:0] = addr_hi_q;
      OFS_ADDR_L: bus_rdata[7:0] = addr_lo_q;
      OFS_PDATA:  bus_rdata[7:0] = pdata_q;
      OFS_PMODE:  bus_rdata[0]   = pmode_q;
      OFS_RDATA:  bus_rdata[7:0] = rd_byte;
      OFS_FUNC:   bus_rdata[1:0] = func_q;
      OFS_FAIL:   bus_rdata[0]   = fail;
      OFS_STATUS: bus_rdata[0]   = busy;
      default: ;
    endcase
  end

  otp_op_seq #(.ARRAY_AW(ARRAY_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .pwrdn(pwrdn_q), .pmode(pmode_q),
    .func(func_q), .addr({addr_hi_q, addr_lo_q}), .pdata(pdata_q),
    .busy(busy), .fail(fail), .rd_byte(rd_byte),
    .arr_addr(arr_addr), .arr_we(arr_we), .arr_wbyte(arr_wbyte),
    .arr_rbyte(arr_rbyte)
  );

  otp_array_model #(.ARRAY_AW(ARRAY_AW)) u_array (
    .clk(clk), .rst_n(rst_n), .addr(arr_addr), .we(arr_we),
    .wbyte(arr_wbyte), .rbyte(arr_rbyte)
  );

  AST_GO_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_GO) |-> (bus_rdata == 32'h0)); // R3
endmodule

// File: tb/otp_cmd_ctrl_bench.sv
module otp_cmd_ctrl_bench;
  localparam int AW = 10;
  localparam int BC = 3;
  localparam int N  = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [N];

  otp_cmd_ctrl #(.ARRAY_AW(AW), .BUSY_CYCLES(BC)) u_otp_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] ofs, input logic [31:0] d);
    bus_addr = ofs; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] ofs, output logic [31:0] v);
    bus_addr = ofs; bus_we = 1'b0;
    #1 v = bus_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rd(6'h30, v);
    while (v[0]) begin
      n++;
      @(negedge clk);
      rd(6'h30, v);
    end
  endtask

  task automatic op(input int a, input logic [1:0] fn);
    int n;
    wr(6'h04, 32'((a >> 8) & 5'h1F));
    wr(6'h08, 32'(a & 8'hFF));
    wr(6'h20, {30'd0, fn});
    wr(6'h28, 32'h1);
    wait_idle(n);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, v); check("R1 pwrdn", v, 32'h1);
    rd(6'h30, v); check("R1 status", v, 32'h0);
    rd(6'h2C, v); check("R1 fail", v, 32'h0);
    rd(6'h18, v); check("R1 rdata", v, 32'h0);

    // R2 readback and address split
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h04, v); check("R2 addr_hi", v, 32'h1F);
    wr(6'h08, 32'h0000_01A5); rd(6'h08, v); check("R2 addr_lo", v, 32'hA5);
    wr(6'h10, 32'h0000_0F3C); rd(6'h10, v); check("R2 pdata", v, 32'h3C);
    wr(6'h20, 32'h7);         rd(6'h20, v); check("R2 func", v, 32'h3);
    rd(6'h28, v); check("R3 go reads zero", v, 32'h0);

    // R7 launch while powered down
    op(5, 2'b01);
    rd(6'h2C, v); check("R7 pwrdn fail", v, 32'h1);
    rd(6'h18, v); check("R10 rdata kept", v, 32'h0);

    wr(6'h00, 32'h0);
    // R3 busy length
    wr(6'h20, 32'h1);
    wr(6'h28, 32'h1);
    wait_idle(n);
    check("R3 busy cycles", 32'(n), 32'(BC));

    // R1 / R5 sweep reads of an all-zero array
    for (int a = 0; a < N; a++) begin
      op(a, 2'b01);
      rd(6'h2C, v); check("R5 read pass", v, 32'h0);
      rd(6'h18, v); check("R1 array zero", v, 32'h0);
    end

    // R8 program without mode
    wr(6'h10, 32'hFF);
    op(7, 2'b10);
    rd(6'h2C, v); check("R8 no mode fail", v, 32'h1);
    op(7, 2'b01);
    rd(6'h18, v); check("R10 array unchanged", v, 32'h0);

    // R6 program sweeps, two passes accumulate by OR
    wr(6'h14, 32'h1);
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < N; a++) begin
        logic [7:0] d;
        d = (pass == 0) ? 8'((a * 37 + 5) & 8'hFF) : 8'((a ^ 8'h5A) & 8'hFF);
        wr(6'h10, 32'(d));
        op(a, 2'b10);
        model[a] = model[a] | d;
        rd(6'h2C, v); check("R6 prog pass", v, 32'h0);
      end
      for (int a = 0; a < N; a++) begin
        op(a, 2'b01);
        rd(6'h18, v); check("R6 readback", v, 32'(model[a]));
      end
    end

    // R9 bad function codes
    op(9, 2'b11);
    rd(6'h2C, v); check("R9 func3 fail", v, 32'h1);
    rd(6'h18, v); check("R10 rdata kept func3", v, 32'(model[N-1]));
    op(9, 2'b00);
    rd(6'h2C, v); check("R9 func0 fail", v, 32'h1);
    op(9, 2'b01);
    rd(6'h2C, v); check("R9 recover", v, 32'h0);
    rd(6'h18, v); check("R10 array kept R9", v, 32'(model[9]));

    // R4 go while busy ignored
    wr(6'h04, 32'h0); wr(6'h08, 32'h21); wr(6'h20, 32'h1);
    wr(6'h28, 32'h1);
    n = 0;
    rd(6'h30, v);
    while (v[0]) begin
      n++;
      if (n == 1) begin
        wr(6'h28, 32'h1);
      end else begin
        @(negedge clk);
      end
      rd(6'h30, v);
    end
    check("R4 busy length kept", 32'(n), 32'(BC));
    rd(6'h18, v); check("R4 result", v, 32'(model[8'h21]));

    // R11 aliasing through upper address bits
    op(32'h1C00 | 5, 2'b01);
    rd(6'h18, v); check("R11 alias read", v, 32'(model[5]));
    op(32'h1000 | 12, 2'b01);
    rd(6'h18, v); check("R11 alias read2", v, 32'(model[12]));

    // R7 power down again
    wr(6'h00, 32'h1);
    op(3, 2'b01);
    rd(6'h2C, v); check("R7 pwrdn again", v, 32'h1);
    rd(6'h18, v); check("R10 rdata after pd", v, 32'(model[12]));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule